// File: doc/BRIEF.md
# Gather Load First-Fault Sequencer

This block runs one predicated gather of 32-bit words into a vector. It splits the vector into lanes of 32 or 64 bits and forms an address for each lane. The address is a 64-bit base plus that lane's index, with the index extended and optionally multiplied by four. The block walks the lanes in ascending order. For each active lane it sends one read over a single-outstanding request/response port, and it assembles the destination vector from the words that return.

Only the first active lane makes a trapping access. If that access fails, the operation ends with a trap, and the destination and the first-fault mask keep their old values. A failure on any later active lane does not trap. That lane and every lane after it are cleared in a byte-granular first-fault mask, and the destination is zero from the first lane whose mask bit reads zero. A caller sets the mask to all ones before a load. After the load it reads the mask back to see how many lanes hold valid data.

Top module: `gather_ff_seq`

## Requirements
- R1: A lane's request address is `base_i + (off << 2)` when `scaled_i` is 1, and `base_i + off` when it is 0, computed modulo 2^64.
- R2: In 32-bit element mode (`elem64_i`=0) the index is the lane's 32-bit slice and `idx64_i` is ignored. In 64-bit element mode with `idx64_i`=0 the index is the low 32 bits of the lane's 64-bit slice. Such a 32-bit index is zero-extended when `sext_i`=0 and sign-extended when `sext_i`=1. With `elem64_i`=1 and `idx64_i`=1 the full 64-bit slice is used unsigned.
- R3: Lane e occupies bits [32e+31:32e] of `index_i` and `dest_o` in 32-bit mode (4 lanes at the default width), or bits [64e+63:64e] in 64-bit mode (2 lanes). Lane e is active when `pred_i` bit 4e (32-bit mode) or bit 8e (64-bit mode) is 1, and all other predicate bits are ignored. Requests go out in ascending lane order.
- R4: An inactive lane issues no request, and its destination lane is zero.
- R5: An active lane whose word returns without fault, while its mask bit is still 1 and no earlier mask bit was found 0, gets `rsp_data_i` zero-extended to the lane width.
- R6: `req_first_o` is 1 only on the request of the first active lane. A fault on that response raises `trap_o` together with `done_o` one cycle later. No further requests follow, and `dest_o` and `ffr_o` keep their old values.
- R7: A fault on any later active lane never traps. It clears the mask bits of that lane's byte group and of every later lane. Later active lanes still issue their reads, and the operation ends normally.
- R8: From the first lane whose lowest mask bit reads 0 at its turn (either cleared in this operation or already 0 beforehand), that lane and all later lanes receive zero.
- R9: If no lane is active, `done_o` rises one cycle after `start_i`, with `dest_o` all zero, no request, and `ffr_o` unchanged.
- R10: After reset `ffr_o` is all ones, `dest_o` is zero, and `busy_o`, `done_o`, `trap_o` and `req_o` are low. `ffr_set_i` while idle sets `ffr_o` to all ones on the next cycle. `start_i` and `ffr_set_i` are ignored while `busy_o` is 1.
- R11: `req_o` stays high with a stable `req_addr_o` until `rsp_valid_i`. A `rsp_valid_i` that arrives while `req_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (idle only) |
| elem64_i | input | 1 | 1: 64-bit lanes, 0: 32-bit lanes |
| idx64_i | input | 1 | 1: full 64-bit index (64-bit lanes only) |
| sext_i | input | 1 | Sign-extend a 32-bit index |
| scaled_i | input | 1 | Multiply index by 4 |
| pred_i | input | VLEN/8 | Byte-granular lane predicate |
| base_i | input | 64 | Scalar base address |
| index_i | input | VLEN | Per-lane index vector |
| ffr_set_i | input | 1 | Set first-fault mask to all ones (idle only) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | With done_o: first active access faulted |
| dest_o | output | VLEN | Destination vector |
| ffr_o | output | VLEN/8 | First-fault mask |
| req_o | output | 1 | Read request pending |
| req_first_o | output | 1 | Pending request is the trapping first access |
| req_addr_o | output | 64 | Read address |
| rsp_valid_i | input | 1 | Response for the pending request |
| rsp_fault_i | input | 1 | Response reports a failed access |
| rsp_data_i | input | 32 | Returned word |

## Verification
The bench aims at the split between the first active lane and the lanes after it. A fault on a leading lane must trap and leave the destination untouched. A design that trapped on later lanes, or that wrote a partial vector on a trap, would show a wrong `trap_o` or a changed `dest_o`. It also checks that lanes after a fault are cleared in the mask and zeroed, that inactive lanes in between are cleared too, and that a mask left low by an earlier load forces zeros even when nothing faults. An off-by-one in the clear range or a missing sticky flag would leave a data lane or a mask bit standing. The bench also covers sign versus zero extension of negative indices, the `idx64_i` bit being ignored in 32-bit mode, predicate bits that lie off a lane boundary, the empty predicate, and `ffr_set_i` or `start_i` pulsed mid-operation. A design that mixed these up would emit wrong addresses or the wrong number of requests.

// File: rtl/gff_pkg.sv
package gff_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_MEM, ST_FIN} gff_state_e;

  typedef struct packed {
    logic elem64;
    logic idx64;
    logic sext;
    logic scaled;
  } gff_mode_t;
endpackage

// File: rtl/gff_addr_gen.sv
module gff_addr_gen
  import gff_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int N32 = VLEN / 32,
  localparam int N64 = VLEN / 64,
  localparam int LW  = $clog2(N32),
  localparam int PW  = VLEN / 8
) (
  input  gff_mode_t        mode_i,
  input  logic [LW-1:0]    lane_i,
  input  logic [PW-1:0]    pred_i,
  input  logic [VLEN-1:0]  idx_i,
  input  logic [63:0]      base_i,
  output logic             active_o,
  output logic             last_o,
  output logic [63:0]      addr_o
);
  logic [31:0]    w32 [N32];
  logic [63:0]    w64 [N64];
  logic [N32-1:0] act32;
  logic [N64-1:0] act64;
  logic [LW-2:0]  l64;

  for (genvar i = 0; i < N32; i++) begin : g_s32
    assign w32[i]   = idx_i[32*i +: 32];
    assign act32[i] = pred_i[4*i];
  end
  for (genvar i = 0; i < N64; i++) begin : g_s64
    assign w64[i]   = idx_i[64*i +: 64];
    assign act64[i] = pred_i[8*i];
  end

  assign l64 = lane_i[LW-2:0];

  logic [31:0] low32;
  logic [63:0] off;

  always_comb begin
    low32 = mode_i.elem64 ? w64[l64][31:0] : w32[lane_i];
    if (mode_i.elem64 && mode_i.idx64) off = w64[l64];
    else if (mode_i.sext)              off = {{32{low32[31]}}, low32};
    else                               off = {32'b0, low32};
    addr_o   = base_i + (mode_i.scaled ? {off[61:0], 2'b00} : off);
    active_o = mode_i.elem64 ? act64[l64] : act32[lane_i];
    last_o   = mode_i.elem64 ? (lane_i == LW'(N64 - 1)) : (lane_i == LW'(N32 - 1));
  end
endmodule

// File: rtl/gff_lane_store.sv
module gff_lane_store #(
  parameter int VLEN = 128,
  localparam int N32 = VLEN / 32,
  localparam int LW  = $clog2(N32)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            wr_i,
  input  logic [LW-1:0]   lane_i,
  input  logic            elem64_i,
  input  logic [31:0]     word_i,
  output logic [VLEN-1:0] vec_o
);
  for (genvar i = 0; i < N32; i++) begin : g_slot
    logic        hit;
    logic [31:0] wval;
    logic [31:0] slot_q;
    // 64-bit lanes own two slots; the upper one takes the zero extension
    assign hit  = elem64_i ? (lane_i == LW'(i / 2)) : (lane_i == LW'(i));
    assign wval = (elem64_i && (i % 2 == 1)) ? 32'b0 : word_i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          slot_q <= '0;
      else if (clr_i)       slot_q <= '0;
      else if (wr_i && hit) slot_q <= wval;
    end
    assign vec_o[32*i +: 32] = slot_q;
  end
endmodule

// File: rtl/gff_ffr_unit.sv
module gff_ffr_unit #(
  parameter int VLEN = 128,
  localparam int N32 = VLEN / 32,
  localparam int N64 = VLEN / 64,
  localparam int LW  = $clog2(N32),
  localparam int PW  = VLEN / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [LW-1:0] lane_i,
  input  logic          elem64_i,
  output logic [PW-1:0] ffr_o,
  output logic          lane_bit_o
);
  logic [PW-1:0]  ffr_q;
  logic [PW-1:0]  kill;
  logic [N32-1:0] lb32;
  logic [N64-1:0] lb64;

  for (genvar b = 0; b < PW; b++) begin : g_kill
    assign kill[b] = elem64_i ? (LW'(b / 8) >= lane_i) : (LW'(b / 4) >= lane_i);
  end
  for (genvar i = 0; i < N32; i++) begin : g_lb32
    assign lb32[i] = ffr_q[4*i];
  end
  for (genvar i = 0; i < N64; i++) begin : g_lb64
    assign lb64[i] = ffr_q[8*i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ffr_q <= '1;
    else if (set_i) ffr_q <= '1;
    else if (clr_i) ffr_q <= ffr_q & ~kill;
  end

  assign lane_bit_o = elem64_i ? lb64[lane_i[LW-2:0]] : lb32[lane_i];
  assign ffr_o      = ffr_q;

  AST_FFR_NO_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> ((ffr_q & ~$past(ffr_q)) == '0)); // R7
endmodule

// File: rtl/gather_ff_seq.sv
module gather_ff_seq
  import gff_pkg::*;
#(
  parameter int VLEN = 128,
  localparam int N32 = VLEN / 32,
  localparam int N64 = VLEN / 64,
  localparam int LW  = $clog2(N32),
  localparam int PW  = VLEN / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            elem64_i,
  input  logic            idx64_i,
  input  logic            sext_i,
  input  logic            scaled_i,
  input  logic [PW-1:0]   pred_i,
  input  logic [63:0]     base_i,
  input  logic [VLEN-1:0] index_i,
  input  logic            ffr_set_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            trap_o,
  output logic [VLEN-1:0] dest_o,
  output logic [PW-1:0]   ffr_o,
  output logic            req_o,
  output logic            req_first_o,
  output logic [63:0]     req_addr_o,
  input  logic            rsp_valid_i,
  input  logic            rsp_fault_i,
  input  logic [31:0]     rsp_data_i
);
  gff_state_e      state_q;
  gff_mode_t       mode_q;
  logic [PW-1:0]   pred_q;
  logic [63:0]     base_q;
  logic [VLEN-1:0] idx_q;
  logic [LW-1:0]   lane_q;
  logic            first_q, faulted_q, unknown_q;
  logic [VLEN-1:0] dest_q;
  logic            done_q, trap_q;
  logic            past_ok_q;

  logic            lane_act, lane_last, lane_bit;
  logic [63:0]     lane_addr;
  logic [VLEN-1:0] work_vec;

  // any active lane among the incoming predicate
  logic [N32-1:0] in32;
  logic [N64-1:0] in64;
  logic           any_act;
  for (genvar i = 0; i < N32; i++) begin : g_in32
    assign in32[i] = pred_i[4*i];
  end
  for (genvar i = 0; i < N64; i++) begin : g_in64
    assign in64[i] = pred_i[8*i];
  end
  assign any_act = elem64_i ? |in64 : |in32;

  logic accept, rsp_hit, first_trap, step, lane_flt, lane_unk;
  logic [31:0] lane_word;

  assign accept     = (state_q == ST_IDLE) && start_i && any_act;
  assign rsp_hit    = (state_q == ST_MEM) && rsp_valid_i;
  assign first_trap = rsp_hit && first_q && rsp_fault_i;
  assign step       = ((state_q == ST_SCAN) && !lane_act) || (rsp_hit && !first_trap);
  assign lane_flt   = faulted_q || (rsp_hit && rsp_fault_i && !first_q);
  assign lane_unk   = unknown_q || lane_flt || !lane_bit;
  assign lane_word  = (rsp_hit && !lane_unk) ? rsp_data_i : 32'b0;

  gff_addr_gen #(.VLEN(VLEN)) u_addr (
    .mode_i  (mode_q),
    .lane_i  (lane_q),
    .pred_i  (pred_q),
    .idx_i   (idx_q),
    .base_i  (base_q),
    .active_o(lane_act),
    .last_o  (lane_last),
    .addr_o  (lane_addr)
  );

  gff_lane_store #(.VLEN(VLEN)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (accept),
    .wr_i    (step),
    .lane_i  (lane_q),
    .elem64_i(mode_q.elem64),
    .word_i  (lane_word),
    .vec_o   (work_vec)
  );

  gff_ffr_unit #(.VLEN(VLEN)) u_ffr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (ffr_set_i && (state_q == ST_IDLE)),
    .clr_i     (step && lane_flt),
    .lane_i    (lane_q),
    .elem64_i  (mode_q.elem64),
    .ffr_o     (ffr_o),
    .lane_bit_o(lane_bit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      mode_q    <= '0;
      pred_q    <= '0;
      base_q    <= '0;
      idx_q     <= '0;
      lane_q    <= '0;
      first_q   <= 1'b0;
      faulted_q <= 1'b0;
      unknown_q <= 1'b0;
      dest_q    <= '0;
      done_q    <= 1'b0;
      trap_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            mode_q    <= '{elem64: elem64_i, idx64: idx64_i, sext: sext_i, scaled: scaled_i};
            pred_q    <= pred_i;
            base_q    <= base_i;
            idx_q     <= index_i;
            lane_q    <= '0;
            first_q   <= 1'b1;
            faulted_q <= 1'b0;
            unknown_q <= 1'b0;
            state_q   <= ST_SCAN;
          end else if (start_i) begin
            dest_q <= '0;
            done_q <= 1'b1;
          end
        end
        ST_SCAN, ST_MEM: begin
          if (first_trap) begin
            trap_q  <= 1'b1;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (state_q == ST_SCAN && lane_act) begin
            state_q <= ST_MEM;
          end else if (step) begin
            if (rsp_hit) first_q <= 1'b0;
            faulted_q <= lane_flt;
            unknown_q <= lane_unk;
            lane_q    <= lane_q + LW'(1);
            state_q   <= lane_last ? ST_FIN : ST_SCAN;
          end
        end
        ST_FIN: begin
          dest_q  <= work_vec;
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok_q <= 1'b0;
    else         past_ok_q <= 1'b1;
  end

  assign busy_o      = state_q != ST_IDLE;
  assign done_o      = done_q;
  assign trap_o      = trap_q;
  assign dest_o      = dest_q;
  assign req_o       = state_q == ST_MEM;
  assign req_first_o = req_o && first_q;
  assign req_addr_o  = lane_addr;

  AST_REQ_ONLY_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> lane_act); // R4
  AST_TRAP_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> done_o); // R6
  AST_DEST_ONLY_AT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && !$stable(dest_o)) |-> done_o); // R6
  AST_LATE_FAULT_NO_TRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !req_first_o && rsp_valid_i) |=> !trap_o); // R7
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !rsp_valid_i) |=> (req_o && $stable(req_addr_o))); // R11
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !req_o); // R9
endmodule

// File: tb/gather_ff_seq_bench.sv
`timescale 1ns/1ps
module gather_ff_seq_bench;
  localparam int VLEN = 128;
  localparam int PW   = VLEN / 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic            start, e64, i64, sx, sc, fset;
  logic [PW-1:0]   pred;
  logic [63:0]     base;
  logic [VLEN-1:0] idx;
  logic            busy, done, trap, req, req_first;
  logic [VLEN-1:0] dest;
  logic [PW-1:0]   ffr;
  logic [63:0]     req_addr;
  logic            mem_v, stray_v, rsp_fault;
  logic            rsp_valid;
  logic [31:0]     rsp_data;
  assign rsp_valid = mem_v | stray_v;

  gather_ff_seq #(.VLEN(VLEN)) u_gather_ff_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .elem64_i(e64), .idx64_i(i64),
    .sext_i(sx), .scaled_i(sc), .pred_i(pred), .base_i(base), .index_i(idx),
    .ffr_set_i(fset), .busy_o(busy), .done_o(done), .trap_o(trap), .dest_o(dest),
    .ffr_o(ffr), .req_o(req), .req_first_o(req_first), .req_addr_o(req_addr),
    .rsp_valid_i(rsp_valid), .rsp_fault_i(rsp_fault), .rsp_data_i(rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return a[31:0] ^ {a[47:32], a[63:48]} ^ 32'hC0DE_0001;
  endfunction

  // memory model and request monitor
  logic [63:0] exp_addr [16];
  logic        exp_first [16];
  int          exp_n;
  int          req_cnt;
  int          lat, wcnt;
  logic        flt_en;
  logic [63:0] flt_addr;

  always @(negedge clk) begin
    if (mem_v) begin
      mem_v = 1'b0;
    end else if (req) begin
      if (wcnt >= lat) begin
        wcnt = 0;
        if (req_cnt < exp_n) begin
          chk(req_addr == exp_addr[req_cnt], "R1 R2 R3 request address", 128'(req_addr), 128'(exp_addr[req_cnt]));
          chk(req_first == exp_first[req_cnt], "R6 first-access flag", 128'(req_first), 128'(exp_first[req_cnt]));
        end else begin
          chk(1'b0, "R4 R6 unexpected request", 128'(req_cnt), 128'(exp_n));
        end
        req_cnt++;
        rsp_data  = mem_word(req_addr);
        rsp_fault = flt_en && (req_addr == flt_addr);
        mem_v     = 1'b1;
      end else begin
        wcnt++;
      end
    end
  end

  typedef struct packed {
    logic          pre;
    logic          e64;
    logic          i64;
    logic          sx;
    logic          sc;
    logic [15:0]   pred;
    logic [63:0]   base;
    logic [127:0]  idx;
    logic          fen;
    logic [63:0]   faddr;
    logic [1:0]    lat;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t TBL [NV] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,16'hFFFF,64'h1000,{32'h30,32'h20,32'h10,32'h4},1'b0,64'h0,2'd0},
    '{1'b1,1'b0,1'b0,1'b1,1'b1,16'h1111,64'h8000_0000_0000_0000,{32'hFFFF_FFFF,32'h8000_0000,32'h7FFF_FFFF,32'hFFFF_FFF0},1'b0,64'h0,2'd1},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,16'h1E0F,64'h0000_00AB_0000_0000,{32'hFFFF_FFFF,32'h8000_0000,32'h7FFF_FFFF,32'hFFFF_FFF0},1'b0,64'h0,2'd0},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,16'hFFFF,64'h10,{64'h0FFF_0000_0000_1000,64'hFFFF_FFFF_FFFF_FFFF},1'b0,64'h0,2'd1},
    '{1'b1,1'b1,1'b0,1'b1,1'b0,16'h0100,64'h10_0000,{64'hDEAD_BEEF_8000_0008,64'h1234_5678_0000_0001},1'b0,64'h0,2'd0},
    '{1'b1,1'b0,1'b0,1'b0,1'b0,16'h1110,64'h2000,{32'h30,32'h20,32'h10,32'h0},1'b1,64'h2010,2'd1},
    '{1'b1,1'b0,1'b0,1'b0,1'b1,16'hFFFF,64'h4000,{32'h3,32'h2,32'h1,32'h0},1'b1,64'h4008,2'd0},
    '{1'b0,1'b0,1'b0,1'b0,1'b1,16'hFFFF,64'h5000,{32'h3,32'h2,32'h1,32'h0},1'b0,64'h0,2'd2},
    '{1'b1,1'b1,1'b1,1'b0,1'b1,16'h0101,64'h9000,{64'h5,64'h1},1'b1,64'h9014,2'd2},
    '{1'b1,1'b0,1'b1,1'b1,1'b0,16'hFFFF,64'h7000,{32'hFFFF_FFFC,32'h8,32'h4,32'h0},1'b0,64'h0,2'd0}
  };

  // reference model from the requirements
  logic [PW-1:0]   ffr_model;
  logic [VLEN-1:0] dest_model;
  logic [VLEN-1:0] exp_dest;
  logic [PW-1:0]   exp_ffr;
  logic            exp_trap;

  task automatic model(input vec_t v);
    int es8, n, k;
    logic first, flt, unk, tr;
    logic [VLEN-1:0] d;
    logic [PW-1:0]   f;
    es8 = v.e64 ? 8 : 4;
    n   = v.e64 ? VLEN / 64 : VLEN / 32;
    first = 1'b1; flt = 1'b0; unk = 1'b0; tr = 1'b0; k = 0; d = '0; f = ffr_model;
    for (int e = 0; e < n; e++) begin
      logic [31:0] data, s32;
      logic [63:0] off, a;
      logic        lf;
      data = '0; lf = flt;
      if (v.pred[e*es8]) begin
        s32 = v.e64 ? v.idx[64*e +: 32] : v.idx[32*e +: 32];
        if (v.e64 && v.i64) off = v.idx[64*e +: 64];
        else if (v.sx)      off = {{32{s32[31]}}, s32};
        else                off = {32'b0, s32};
        a = v.base + (v.sc ? (off << 2) : off);
        exp_addr[k] = a; exp_first[k] = first; k++;
        if (first && v.fen && a == v.faddr) begin tr = 1'b1; break; end
        if (!first && v.fen && a == v.faddr) lf = 1'b1;
        first = 1'b0;
        data  = mem_word(a);
      end
      flt = lf;
      if (flt) for (int b = e*es8; b < PW; b++) f[b] = 1'b0;
      unk = unk | !f[e*es8];
      if (v.e64) d[64*e +: 64] = unk ? 64'b0 : {32'b0, data};
      else       d[32*e +: 32] = unk ? 32'b0 : data;
    end
    exp_n    = k;
    exp_trap = tr;
    exp_dest = tr ? dest_model : d;
    exp_ffr  = tr ? ffr_model : f;
  endtask

  task automatic set_ffr();
    @(negedge clk) fset = 1'b1;
    @(negedge clk) fset = 1'b0;
    ffr_model = '1;
  endtask

  task automatic drive(input vec_t v);
    e64 = v.e64; i64 = v.i64; sx = v.sx; sc = v.sc; pred = v.pred;
    base = v.base; idx = v.idx; flt_en = v.fen; flt_addr = v.faddr; lat = int'(v.lat);
  endtask

  task automatic wait_done(output bit ok);
    int t;
    t = 0;
    while (!done && t < 500) begin @(negedge clk); t++; end
    ok = done;
  endtask

  task automatic run_vec(input vec_t v, input int vi);
    bit ok;
    if (v.pre) set_ffr();
    model(v);
    req_cnt = 0; wcnt = 0;
    @(negedge clk);
    drive(v); start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done(ok);
    chk(ok, $sformatf("R3 vec %0d done seen", vi), 128'(ok), 128'(1));
    chk(trap == exp_trap, $sformatf("R6 R7 vec %0d trap", vi), 128'(trap), 128'(exp_trap));
    chk(dest == exp_dest, $sformatf("R4 R5 R8 vec %0d dest", vi), dest, exp_dest);
    chk(ffr == exp_ffr, $sformatf("R7 vec %0d mask", vi), 128'(ffr), 128'(exp_ffr));
    chk(req_cnt == exp_n, $sformatf("R4 vec %0d request count", vi), 128'(req_cnt), 128'(exp_n));
    dest_model = exp_dest;
    ffr_model  = exp_ffr;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    bit ok;
    vec_t v;
    rst_n = 1'b0; start = 1'b0; fset = 1'b0; e64 = 1'b0; i64 = 1'b0; sx = 1'b0; sc = 1'b0;
    pred = '0; base = '0; idx = '0; mem_v = 1'b0; stray_v = 1'b0; rsp_fault = 1'b0;
    rsp_data = '0; lat = 0; wcnt = 0; req_cnt = 0; exp_n = 0; flt_en = 1'b0; flt_addr = '0;
    ffr_model = '1; dest_model = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(ffr == '1, "R10 reset mask", 128'(ffr), 128'(16'hFFFF));
    chk(dest == '0, "R10 reset dest", dest, 128'(0));
    chk({busy, done, trap, req} == 4'b0, "R10 reset controls", 128'({busy, done, trap, req}), 128'(0));

    for (int i = 0; i < NV; i++) run_vec(TBL[i], i);

    // R9 empty predicate, mask left low from a late fault
    v = TBL[6];
    run_vec(v, 100);
    model(v);
    exp_n = 0; req_cnt = 0;
    @(negedge clk);
    drive(v); pred = 16'hEEEE; start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(done == 1'b1, "R9 done one cycle after start", 128'(done), 128'(1));
    chk(dest == '0, "R9 empty dest", dest, 128'(0));
    chk(ffr == 16'h00FF, "R9 mask unchanged", 128'(ffr), 128'(16'h00FF));
    chk(req_cnt == 0, "R9 no request", 128'(req_cnt), 128'(0));
    dest_model = '0;
    ffr_model  = 16'h00FF;

    // R11 stray response while idle
    @(negedge clk) stray_v = 1'b1;
    @(negedge clk) stray_v = 1'b0;
    chk(!done && !busy && dest == '0, "R11 stray response ignored", 128'({done, busy}), 128'(0));

    // R10 set while idle
    set_ffr();
    chk(ffr == '1, "R10 set while idle", 128'(ffr), 128'(16'hFFFF));

    // R10 set and start ignored while busy
    v = TBL[6]; v.lat = 2'd3;
    model(v);
    req_cnt = 0; wcnt = 0;
    @(negedge clk);
    drive(v); start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (6) @(negedge clk);
    fset = 1'b1; start = 1'b1; pred = 16'h0001;
    @(negedge clk) fset = 1'b0; start = 1'b0;
    wait_done(ok);
    chk(ok && !trap, "R10 busy run completes", 128'({ok, trap}), 128'(2'b10));
    chk(ffr == 16'h00FF, "R10 set ignored while busy", 128'(ffr), 128'(16'h00FF));
    chk(req_cnt == 4, "R10 start ignored while busy", 128'(req_cnt), 128'(4));
    chk(dest == exp_dest, "R8 busy run dest", dest, exp_dest);
    @(negedge clk);
    chk(!busy && !done, "R10 no second run", 128'({busy, done}), 128'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule